// File: doc/BRIEF.md
# Half-Bridge Fault Protection Supervisor

This block holds the command and protection state for a set of independently driven half-bridge output stages. Each channel is told to drive its high-side switch, its low-side switch, or neither. Two channels commanded in opposite directions form an H-bridge. That pair can then drive forward, reverse, brake (both low) or high impedance. The block turns the stored commands into registered gate-enable outputs. It never enables both switches of one channel at once.

The block watches three digitized comparators on each channel: overcurrent, hard current limit and under-load. It also watches two global supply flags. Persistent faults are filtered by timers that count pulses of an external millisecond tick. The block reacts according to two configuration bits. An overcurrent can either only raise the overload flag, or latch the channel off once the fault has persisted. A supply overvoltage can either only raise the supply-fault flag, or also blank every output until the supply recovers. A hard current limit that persists always latches its channel off. Supply undervoltage holds all outputs off with no flag.

All latches and flags are cleared only by a command write that carries the status-reset request. A reset request is refused for any latch or flag whose fault condition is still present in the same cycle.

Top module: `hb_fault_sup`

## Requirements
- R1: After synchronous reset, every gate enable, every readback bit and the overload, under-load and supply-fault flags are 0.
- R2: On a write, channel i takes its command from cmd_mode[2i+1:2i]: 00 both switches off, 01 high side on, 10 low side on, 11 both off. The gate enables follow on the second clock edge after the write. A channel's high-side and low-side enables are never 1 together.
- R3: With cmd_oc_latch=0, an overcurrent on a driving channel sets the overload flag. The channel keeps driving, however many ticks pass.
- R4: With cmd_oc_latch=1, an overcurrent held on a driving channel for OC_TICKS tick pulses latches that channel off, clears its readback and sets the overload flag. After OC_TICKS-1 pulses the channel still drives and the flag is 0. The timer restarts from zero whenever the overcurrent drops.
- R5: A current limit held on a driving channel for ILIM_TICKS tick pulses latches the channel off and sets the overload flag, whatever cmd_oc_latch says. After ILIM_TICKS-1 pulses the channel still drives.
- R6: Under-load held on a driving channel for UL_TICKS tick pulses sets the under-load flag, and the channel keeps driving. Under-load on a channel that is not driving never sets the flag.
- R7: A supply overvoltage always sets the supply-fault flag. With cmd_ov_off=1, every output is forced off while it lasts. When it ends, the stored commands drive again without a new write. With cmd_ov_off=0, the outputs are unaffected.
- R8: While supply undervoltage is asserted, every output is off. Command writes are still accepted, and the outputs follow the newest command once the undervoltage ends.
- R9: A write with cmd_srr=1 clears the latched-off channels and all three flags. A write with cmd_srr=0 clears none of them.
- R10: A reset request is ignored by a channel latch whose overcurrent or current-limit input is high in that cycle. It is also ignored by the overload flag while any channel has either input high, and by the supply-fault flag while overvoltage is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_ms | input | 1 | One-cycle millisecond pulse for the fault timers |
| cmd_wr | input | 1 | Command write strobe |
| cmd_mode | input | 2*NCH | Per-channel drive command |
| cmd_oc_latch | input | 1 | Overcurrent reaction: 1 latches off after filter |
| cmd_ov_off | input | 1 | Overvoltage reaction: 1 blanks all outputs |
| cmd_srr | input | 1 | Status-reset request carried with a write |
| oc_cmp | input | NCH | Overcurrent comparator per channel |
| ilim_cmp | input | NCH | Hard current-limit comparator per channel |
| ul_cmp | input | NCH | Under-load comparator per channel |
| sup_uv | input | 1 | Supply undervoltage |
| sup_ov | input | 1 | Supply overvoltage |
| hs_en | output | NCH | High-side gate enables |
| ls_en | output | NCH | Low-side gate enables |
| ch_rb | output | NCH | Readback: commanded on and not latched off |
| ovl_status | output | 1 | Overload flag |
| ul_status | output | 1 | Under-load flag |
| sf_status | output | 1 | Supply-fault flag |

## Verification
The bench sweeps all 64 command combinations over three channels. This catches a decoder that lets code 11 turn a switch on, or that swaps the channel fields. The fault timers are probed one pulse before and at their threshold, and again after the fault drops out briefly. An off-by-one or a timer that does not restart would latch early or late. The reset request is tried with a fault still present and with a write that lacks the request bit. A clear that ignores the blocking rule would turn a faulty channel back on. The bench also checks that stored commands come back after overvoltage blanking and after undervoltage, which a design that dropped the commands would fail.

// File: rtl/hbg_pkg.sv
// Package: shared command encoding for the half-bridge supervisor.
// Assumes a two-bit command field per channel.
package hbg_pkg;
    typedef enum logic [1:0] {
        HB_OFF  = 2'b00,
        HB_HIGH = 2'b01,
        HB_LOW  = 2'b10,
        HB_BAD  = 2'b11
    } hb_mode_e;

    // True when the command asks the channel to drive one switch.
    function automatic logic mode_active(input hb_mode_e m);
        return (m == HB_HIGH) || (m == HB_LOW);
    endfunction
endpackage

// File: rtl/hbg_tick_filter.sv
// Persistence filter: counts tick pulses while cond is high and saturates
// at THR. Assumes THR >= 1 and that tick is a one-cycle pulse. The count
// returns to zero in the cycle after cond drops.
module hbg_tick_filter #(
    parameter int THR = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cond,
    output logic done
);
    localparam int W = $clog2(THR + 1);
    localparam logic [W-1:0] LIMIT = W'(THR);

    logic [W-1:0] cnt_q;

    // Count pulses during the condition; restart when it clears.
    always_ff @(posedge clk) begin
        if (!rst_n || !cond) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = cond && (cnt_q == LIMIT);
endmodule

// File: rtl/hbg_channel.sv
// One half-bridge channel: decodes its command, owns the latch-off state,
// runs the overcurrent, current-limit and under-load filters, and registers
// the gate enables. Assumes the comparator inputs are already synchronous.
module hbg_channel
    import hbg_pkg::*;
#(
    parameter int OC_TICKS   = 25,
    parameter int ILIM_TICKS = 200,
    parameter int UL_TICKS   = 50
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  hb_mode_e mode,
    input  logic     oc_latch_cfg,
    input  logic     block,
    input  logic     srr,
    input  logic     oc,
    input  logic     ilim,
    input  logic     ul,
    output logic     hs_en,
    output logic     ls_en,
    output logic     rb,
    output logic     ovl_set,
    output logic     ul_set
);
    logic latched_q;
    logic drive;
    logic oc_done;
    logic il_done;
    logic ul_done;

    assign drive = hs_en | ls_en;

    hbg_tick_filter #(.THR(OC_TICKS)) oc_filt_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cond(oc && drive && oc_latch_cfg), .done(oc_done)
    );

    hbg_tick_filter #(.THR(ILIM_TICKS)) il_filt_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cond(ilim && drive), .done(il_done)
    );

    hbg_tick_filter #(.THR(UL_TICKS)) ul_filt_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cond(ul && drive), .done(ul_done)
    );

    // Latch-off state: set by an expired filter, cleared by a reset request
    // only while neither current fault is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latched_q <= 1'b0;
        end else if (oc_done || il_done) begin
            latched_q <= 1'b1;
        end else if (srr && !oc && !ilim) begin
            latched_q <= 1'b0;
        end
    end

    // Gate enables: the decoded command, gated by latch-off and supply blanking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_en <= 1'b0;
            ls_en <= 1'b0;
        end else begin
            hs_en <= (mode == HB_HIGH) && !latched_q && !block;
            ls_en <= (mode == HB_LOW)  && !latched_q && !block;
        end
    end

    assign rb      = mode_active(mode) && !latched_q;
    assign ovl_set = (oc && drive && !oc_latch_cfg) || oc_done || il_done;
    assign ul_set  = ul_done;
endmodule

// File: rtl/hbg_status.sv
// Status flags and supply handling. Holds the overload, under-load and
// supply-fault flags. A set wins over a clear, and a clear is refused while
// its condition is present. Also produces the output blanking signal.
module hbg_status #(
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           srr,
    input  logic           sup_uv,
    input  logic           sup_ov,
    input  logic           ov_off_cfg,
    input  logic [NCH-1:0] ovl_set,
    input  logic [NCH-1:0] ul_set,
    input  logic [NCH-1:0] oc,
    input  logic [NCH-1:0] ilim,
    input  logic [NCH-1:0] ul,
    input  logic [NCH-1:0] drive,
    output logic           block,
    output logic           ovl_q,
    output logic           ul_q,
    output logic           sf_q
);
    logic ovl_clr;
    logic ul_clr;
    logic sf_clr;

    assign ovl_clr = srr && !(|(oc | ilim));
    assign ul_clr  = srr && !(|(ul & drive));
    assign sf_clr  = srr && !sup_ov;
    assign block   = sup_uv || (sup_ov && ov_off_cfg);

    // Flag registers: sticky until an accepted reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovl_q <= 1'b0;
            ul_q  <= 1'b0;
            sf_q  <= 1'b0;
        end else begin
            ovl_q <= (|ovl_set) || (ovl_q && !ovl_clr);
            ul_q  <= (|ul_set)  || (ul_q  && !ul_clr);
            sf_q  <= sup_ov     || (sf_q  && !sf_clr);
        end
    end
endmodule

// File: rtl/hb_fault_sup.sv
// Top of the half-bridge fault supervisor. Stores the command and the
// configuration written with cmd_wr, instantiates one channel per output and
// the shared status logic. Assumes all inputs are synchronous to clk.
module hb_fault_sup
    import hbg_pkg::*;
#(
    parameter int NCH        = 3,
    parameter int OC_TICKS   = 25,
    parameter int ILIM_TICKS = 200,
    parameter int UL_TICKS   = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_ms,
    input  logic             cmd_wr,
    input  logic [2*NCH-1:0] cmd_mode,
    input  logic             cmd_oc_latch,
    input  logic             cmd_ov_off,
    input  logic             cmd_srr,
    input  logic [NCH-1:0]   oc_cmp,
    input  logic [NCH-1:0]   ilim_cmp,
    input  logic [NCH-1:0]   ul_cmp,
    input  logic             sup_uv,
    input  logic             sup_ov,
    output logic [NCH-1:0]   hs_en,
    output logic [NCH-1:0]   ls_en,
    output logic [NCH-1:0]   ch_rb,
    output logic             ovl_status,
    output logic             ul_status,
    output logic             sf_status
);
    localparam int MW = 2 * NCH;

    logic [MW-1:0]  mode_q;
    logic           oc_latch_q;
    logic           ov_off_q;
    logic           srr_p;
    logic           block;
    logic [NCH-1:0] ovl_set;
    logic [NCH-1:0] ul_set;

    assign srr_p = cmd_wr && cmd_srr;

    // Command register: loaded on every write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= '0;
            oc_latch_q <= 1'b0;
            ov_off_q   <= 1'b0;
        end else if (cmd_wr) begin
            mode_q     <= cmd_mode;
            oc_latch_q <= cmd_oc_latch;
            ov_off_q   <= cmd_ov_off;
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        hbg_channel #(
            .OC_TICKS(OC_TICKS), .ILIM_TICKS(ILIM_TICKS), .UL_TICKS(UL_TICKS)
        ) ch_i (
            .clk(clk), .rst_n(rst_n), .tick(tick_ms),
            .mode(hb_mode_e'(mode_q[2*i +: 2])),
            .oc_latch_cfg(oc_latch_q), .block(block), .srr(srr_p),
            .oc(oc_cmp[i]), .ilim(ilim_cmp[i]), .ul(ul_cmp[i]),
            .hs_en(hs_en[i]), .ls_en(ls_en[i]), .rb(ch_rb[i]),
            .ovl_set(ovl_set[i]), .ul_set(ul_set[i])
        );
    end

    hbg_status #(.NCH(NCH)) stat_i (
        .clk(clk), .rst_n(rst_n), .srr(srr_p),
        .sup_uv(sup_uv), .sup_ov(sup_ov), .ov_off_cfg(ov_off_q),
        .ovl_set(ovl_set), .ul_set(ul_set),
        .oc(oc_cmp), .ilim(ilim_cmp), .ul(ul_cmp), .drive(hs_en | ls_en),
        .block(block), .ovl_q(ovl_status), .ul_q(ul_status), .sf_q(sf_status)
    );
endmodule

// File: rtl/hb_fault_sup_chk.sv
// Property checker for hb_fault_sup, attached with bind. Observes ports and
// the stored overvoltage configuration.
module hb_fault_sup_chk #(
    parameter int NCH = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_wr,
    input logic [2*NCH-1:0] cmd_mode,
    input logic             cmd_srr,
    input logic [NCH-1:0]   oc_cmp,
    input logic [NCH-1:0]   ilim_cmp,
    input logic             sup_uv,
    input logic             sup_ov,
    input logic             ov_off,
    input logic [NCH-1:0]   hs_en,
    input logic [NCH-1:0]   ls_en,
    input logic             ovl_status,
    input logic             sf_status
);
    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en & ls_en) == '0);

    assert_bad_code_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_mode[1:0] == 2'b11) |-> ##2 (!hs_en[0] && !ls_en[0]));

    assert_uv_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sup_uv |=> ((hs_en | ls_en) == '0));

    assert_ov_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_ov && ov_off) |=> ((hs_en | ls_en) == '0));

    assert_ov_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sup_ov |=> sf_status);

    assert_clear_refused_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_srr && ovl_status && (|(oc_cmp | ilim_cmp))) |=> ovl_status);
endmodule

bind hb_fault_sup hb_fault_sup_chk #(.NCH(NCH)) chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_mode(cmd_mode),
    .cmd_srr(cmd_srr), .oc_cmp(oc_cmp), .ilim_cmp(ilim_cmp),
    .sup_uv(sup_uv), .sup_ov(sup_ov), .ov_off(ov_off_q),
    .hs_en(hs_en), .ls_en(ls_en), .ovl_status(ovl_status), .sf_status(sf_status)
);

// File: tb/hb_fault_sup_tb_top.sv
module hb_fault_sup_tb_top;
    localparam int NCH = 3;
    localparam int OCT = 3;
    localparam int ILT = 5;
    localparam int ULT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_ms = 1'b0;
    logic cmd_wr = 1'b0;
    logic [2*NCH-1:0] cmd_mode = '0;
    logic cmd_oc_latch = 1'b0;
    logic cmd_ov_off = 1'b0;
    logic cmd_srr = 1'b0;
    logic [NCH-1:0] oc_cmp = '0;
    logic [NCH-1:0] ilim_cmp = '0;
    logic [NCH-1:0] ul_cmp = '0;
    logic sup_uv = 1'b0;
    logic sup_ov = 1'b0;
    logic [NCH-1:0] hs_en, ls_en, ch_rb;
    logic ovl_status, ul_status, sf_status;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    hb_fault_sup #(.NCH(NCH), .OC_TICKS(OCT), .ILIM_TICKS(ILT), .UL_TICKS(ULT)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .cmd_wr(cmd_wr),
        .cmd_mode(cmd_mode), .cmd_oc_latch(cmd_oc_latch), .cmd_ov_off(cmd_ov_off),
        .cmd_srr(cmd_srr), .oc_cmp(oc_cmp), .ilim_cmp(ilim_cmp), .ul_cmp(ul_cmp),
        .sup_uv(sup_uv), .sup_ov(sup_ov), .hs_en(hs_en), .ls_en(ls_en),
        .ch_rb(ch_rb), .ovl_status(ovl_status), .ul_status(ul_status),
        .sf_status(sf_status)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2*NCH-1:0] m, input logic ocl, input logic ovo, input logic srr);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_mode = m; cmd_oc_latch = ocl; cmd_ov_off = ovo; cmd_srr = srr;
        @(negedge clk);
        cmd_wr = 1'b0; cmd_srr = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick_ms = 1'b1;
            @(negedge clk); tick_ms = 1'b0;
        end
        settle();
    endtask

    // Return to a clean state: no faults, all flags and latches cleared.
    task automatic clean();
        oc_cmp = '0; ilim_cmp = '0; ul_cmp = '0; sup_uv = 1'b0; sup_ov = 1'b0;
        wr('0, 1'b0, 1'b0, 1'b1);
        settle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 enables", {hs_en, ls_en, ch_rb}, '0);
        check("R1 flags", {ovl_status, ul_status, sf_status}, '0);

        // R2: exhaustive sweep of all command combinations
        for (int m = 0; m < 64; m++) begin
            logic [NCH-1:0] eh, el, er;
            for (int c = 0; c < NCH; c++) begin
                logic [1:0] f;
                f = 2'(m >> (2 * c));
                eh[c] = (f == 2'b01);
                el[c] = (f == 2'b10);
                er[c] = (f == 2'b01) || (f == 2'b10);
            end
            wr(6'(m), 1'b0, 1'b0, 1'b0);
            settle();
            check("R2 high side", hs_en, eh);
            check("R2 low side", ls_en, el);
            check("R2 readback", ch_rb, er);
        end

        // R3: overcurrent with flag-only reaction
        clean();
        wr(6'b10_00_00, 1'b0, 1'b0, 1'b0);
        settle();
        oc_cmp = 3'b100;
        ticks(10);
        check("R3 overload flag", ovl_status, 1'b1);
        check("R3 channel keeps driving", ls_en, 3'b100);

        // R4: overcurrent latch-off with filter restart
        clean();
        wr(6'b00_00_01, 1'b1, 1'b0, 1'b0);
        settle();
        oc_cmp = 3'b001;
        ticks(OCT - 1);
        check("R4 before threshold on", hs_en, 3'b001);
        check("R4 before threshold flag", ovl_status, 1'b0);
        oc_cmp = 3'b000;
        settle();
        oc_cmp = 3'b001;
        ticks(OCT - 1);
        check("R4 timer restarts", hs_en, 3'b001);
        ticks(1);
        check("R4 latched off", hs_en, 3'b000);
        check("R4 readback", ch_rb, 3'b000);
        check("R4 flag", ovl_status, 1'b1);

        // R10: request refused while overcurrent present
        wr(6'b00_00_01, 1'b1, 1'b0, 1'b1);
        settle();
        check("R10 latch kept", hs_en, 3'b000);
        check("R10 flag kept", ovl_status, 1'b1);

        // R9: write without request clears nothing, then request clears
        oc_cmp = '0;
        wr(6'b00_00_01, 1'b1, 1'b0, 1'b0);
        settle();
        check("R9 no request keeps latch", hs_en, 3'b000);
        check("R9 no request keeps flag", ovl_status, 1'b1);
        wr(6'b00_00_01, 1'b1, 1'b0, 1'b1);
        settle();
        check("R9 latch cleared", hs_en, 3'b001);
        check("R9 flag cleared", ovl_status, 1'b0);

        // R5: current limit latches off even with flag-only overcurrent setting
        clean();
        wr(6'b00_10_00, 1'b0, 1'b0, 1'b0);
        settle();
        ilim_cmp = 3'b010;
        ticks(ILT - 1);
        check("R5 before threshold", ls_en, 3'b010);
        ticks(1);
        check("R5 latched off", ls_en, 3'b000);
        check("R5 readback", ch_rb, 3'b000);
        check("R5 flag", ovl_status, 1'b1);

        // R6: under-load on driving vs idle channel
        clean();
        wr(6'b00_00_01, 1'b0, 1'b0, 1'b0);
        settle();
        ul_cmp = 3'b010;
        ticks(ULT + 2);
        check("R6 idle channel no flag", ul_status, 1'b0);
        ul_cmp = 3'b001;
        ticks(ULT - 1);
        check("R6 before threshold", ul_status, 1'b0);
        ticks(1);
        check("R6 flag set", ul_status, 1'b1);
        check("R6 channel keeps driving", hs_en, 3'b001);

        // R7: overvoltage with and without blanking
        clean();
        wr(6'b01_10_01, 1'b0, 1'b0, 1'b0);
        settle();
        sup_ov = 1'b1;
        settle();
        check("R7 no blanking", {hs_en, ls_en}, {3'b101, 3'b010});
        check("R7 flag", sf_status, 1'b1);
        wr(6'b01_10_01, 1'b0, 1'b1, 1'b1);
        settle();
        check("R7 blanked", {hs_en, ls_en}, '0);
        check("R10 supply flag kept", sf_status, 1'b1);
        sup_ov = 1'b0;
        settle();
        check("R7 restored", {hs_en, ls_en}, {3'b101, 3'b010});
        check("R7 flag sticky", sf_status, 1'b1);
        wr(6'b01_10_01, 1'b0, 1'b1, 1'b1);
        settle();
        check("R9 supply flag cleared", sf_status, 1'b0);

        // R8: undervoltage blanking with write accepted meanwhile
        sup_uv = 1'b1;
        settle();
        check("R8 blanked", {hs_en, ls_en}, '0);
        wr(6'b10_01_10, 1'b0, 1'b0, 1'b0);
        settle();
        check("R8 still blanked", {hs_en, ls_en}, '0);
        sup_uv = 1'b0;
        settle();
        check("R8 new command applied", {hs_en, ls_en}, {3'b010, 3'b101});
        check("R8 no flag", {ovl_status, ul_status, sf_status}, '0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule